// File: doc/BRIEF.md
# Spike Classifier Configuration and Mode Control Unit

This unit is the host-side front end of a spike-classification engine. A 3-bit operation code chooses what the unit does on each clock: shift principal-component coefficients into one of two coefficient memories, write one of sixteen 8-bit configuration registers, read one back, enable sorting, or do nothing. The datapath that detects and classifies spikes is outside this unit. It reads the coefficient memories in parallel and takes the detection threshold and the two separation-line parameters from dedicated register taps.

Coefficients arrive as 5-bit samples. Each coefficient memory is a shift chain with one entry per sample of a spike window. A 1-bit select chooses which principal component is being loaded. Register traffic uses a 4-bit address with separate 8-bit write and read buses. Reads return data on a registered output one cycle after the address is sampled. All state clears on a synchronous, active-high reset.

Top module: `spk_cfg_ctrl`

## Requirements
- R1: `op_mode` codes are: 0 idle, 1 coefficient load, 2 register write, 3 register read, 4 sort. Codes 5, 6 and 7 act exactly as idle.
- R2: With `op_mode`=2 and `in_valid`=1 at a clock edge, `cr_wdata` is stored into the register at `cr_addr`. The new value is visible on that register's tap in the next cycle.
- R3: With `op_mode`=2 and `in_valid`=0, no register changes.
- R4: With `op_mode`=3 at a clock edge, `cr_rdata` shows the register at `cr_addr` in the following cycle. In any other mode `cr_rdata` keeps its value. `in_valid` has no effect on reads.
- R5: With `op_mode`=1 and `in_valid`=1, `spk_sample` enters entry 0 of the memory chosen by `pc_sel` (0 = first component, 1 = second). Each older entry moves up one place, and the other memory stays unchanged. Entry k sits at bits [5k+4:5k] of its flat output.
- R6: With `op_mode`=1 and `in_valid`=0, neither coefficient memory changes.
- R7: Each memory holds `SPK_LEN` entries (16 by default). After `SPK_LEN` shifts, the first sample sits in entry `SPK_LEN`-1, and the next shift discards it.
- R8: `sort_en` is high in the cycle after a clock edge that samples `op_mode`=4, and low after any other code.
- R9: Idle codes (0, 5, 6, 7) change no register, no coefficient, `cr_rdata` or `sort_en`, whatever `in_valid` does.
- R10: With `rst` high at a clock edge, every register, every coefficient entry, `cr_rdata` and `sort_en` become zero.
- R11: Register map: address 0 drives `det_threshold`, 1 `sep_a_slope`, 2 `sep_a_offset`, 3 `sep_b_slope`, 4 `sep_b_offset`. Addresses 5 to 15 are spare storage that can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Operation code |
| in_valid | input | 1 | Qualifies writes and coefficient shifts |
| spk_sample | input | 5 | Coefficient sample to shift in |
| pc_sel | input | 1 | Target coefficient memory: 0 first, 1 second |
| cr_addr | input | 4 | Register address |
| cr_wdata | input | 8 | Register write data |
| cr_rdata | output | 8 | Registered read data |
| sort_en | output | 1 | Sorting enable for the datapath |
| det_threshold | output | 8 | Register 0 tap |
| sep_a_slope | output | 8 | Register 1 tap |
| sep_a_offset | output | 8 | Register 2 tap |
| sep_b_slope | output | 8 | Register 3 tap |
| sep_b_offset | output | 8 | Register 4 tap |
| pc1_coef | output | 80 | First component coefficients, entry k at [5k+4:5k] |
| pc2_coef | output | 80 | Second component coefficients, entry k at [5k+4:5k] |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge. They also assume that reset is asserted at the first edge, so the mode, valid and select lines never feed X into the decode. The bench drives every input on the falling edge and holds reset from time zero. It uses only defined values, but it does walk through the three unused codes 5 to 7 with `in_valid` high, so the idle-alias checks see traffic that would otherwise write.

// File: rtl/spk_cfg_pkg.sv
package spk_cfg_pkg;

  // Operation codes on the 3-bit mode input.
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_SORT  = 3'd4
  } op_code_e;

  // Decoded, valid-qualified command for one cycle.
  typedef struct packed {
    logic shift;
    logic write;
    logic read;
    logic sort;
  } cmd_t;

  // Register map addresses consumed by the datapath.
  localparam int unsigned ADDR_THRESH  = 0;
  localparam int unsigned ADDR_A_SLOPE = 1;
  localparam int unsigned ADDR_A_OFS   = 2;
  localparam int unsigned ADDR_B_SLOPE = 3;
  localparam int unsigned ADDR_B_OFS   = 4;

endpackage

// File: rtl/spk_mode_dec.sv
module spk_mode_dec
  import spk_cfg_pkg::*;
(
  input  logic [2:0] op_mode,
  input  logic       in_valid,
  output cmd_t       cmd
);

  always_comb begin
    cmd = '0;
    unique case (op_mode)
      OP_LOAD:  cmd.shift = in_valid;
      OP_WRITE: cmd.write = in_valid;
      OP_READ:  cmd.read  = 1'b1;
      OP_SORT:  cmd.sort  = 1'b1;
      default:  cmd       = '0;  // idle and unused codes
    endcase
  end

endmodule

// File: rtl/spk_cfg_regs.sv
module spk_cfg_regs #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [(1<<AW)*DW-1:0]  all_regs
);

  localparam int unsigned NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= regs[addr];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_tap
    assign all_regs[g*DW +: DW] = regs[g];
  end

endmodule

// File: rtl/spk_coef_shift.sv
module spk_coef_shift #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] taps
);

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
    end else if (shift_en) begin
      chain[0] <= din;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign taps[g*W +: W] = chain[g];
  end

endmodule

// File: rtl/spk_cfg_ctrl.sv
module spk_cfg_ctrl
  import spk_cfg_pkg::*;
#(
  parameter int unsigned SPK_LEN = 16,
  parameter int unsigned COEF_W  = 5,
  parameter int unsigned CR_AW   = 4,
  parameter int unsigned CR_DW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2:0]                op_mode,
  input  logic                      in_valid,
  input  logic [COEF_W-1:0]         spk_sample,
  input  logic                      pc_sel,
  input  logic [CR_AW-1:0]          cr_addr,
  input  logic [CR_DW-1:0]          cr_wdata,
  output logic [CR_DW-1:0]          cr_rdata,
  output logic                      sort_en,
  output logic [CR_DW-1:0]          det_threshold,
  output logic [CR_DW-1:0]          sep_a_slope,
  output logic [CR_DW-1:0]          sep_a_offset,
  output logic [CR_DW-1:0]          sep_b_slope,
  output logic [CR_DW-1:0]          sep_b_offset,
  output logic [SPK_LEN*COEF_W-1:0] pc1_coef,
  output logic [SPK_LEN*COEF_W-1:0] pc2_coef
);

  localparam int unsigned NREG   = 1 << CR_AW;
  localparam int unsigned NPC    = 2;
  localparam int unsigned FLAT_W = SPK_LEN * COEF_W;

  cmd_t                    cmd;
  logic [NREG*CR_DW-1:0]   reg_flat;
  logic [FLAT_W-1:0]       coef_flat [NPC];

  spk_mode_dec u_dec (
    .op_mode  (op_mode),
    .in_valid (in_valid),
    .cmd      (cmd)
  );

  spk_cfg_regs #(.AW(CR_AW), .DW(CR_DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cmd.write),
    .rd_en    (cmd.read),
    .addr     (cr_addr),
    .wdata    (cr_wdata),
    .rdata    (cr_rdata),
    .all_regs (reg_flat)
  );

  for (genvar g = 0; g < NPC; g++) begin : g_pc
    logic sel_hit;
    assign sel_hit = (pc_sel == g[0]);
    spk_coef_shift #(.DEPTH(SPK_LEN), .W(COEF_W)) u_mem (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cmd.shift && sel_hit),
      .din      (spk_sample),
      .taps     (coef_flat[g])
    );
  end

  assign pc1_coef = coef_flat[0];
  assign pc2_coef = coef_flat[1];

  always_ff @(posedge clk) begin
    if (rst) sort_en <= 1'b0;
    else     sort_en <= cmd.sort;
  end

  assign det_threshold = reg_flat[ADDR_THRESH  * CR_DW +: CR_DW];
  assign sep_a_slope   = reg_flat[ADDR_A_SLOPE * CR_DW +: CR_DW];
  assign sep_a_offset  = reg_flat[ADDR_A_OFS   * CR_DW +: CR_DW];
  assign sep_b_slope   = reg_flat[ADDR_B_SLOPE * CR_DW +: CR_DW];
  assign sep_b_offset  = reg_flat[ADDR_B_OFS   * CR_DW +: CR_DW];

endmodule

// File: rtl/spk_cfg_ctrl_chk.sv
module spk_cfg_ctrl_chk #(
  parameter int unsigned SPK_LEN = 16,
  parameter int unsigned COEF_W  = 5,
  parameter int unsigned CR_AW   = 4,
  parameter int unsigned CR_DW   = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [2:0]                op_mode,
  input logic                      in_valid,
  input logic [COEF_W-1:0]         spk_sample,
  input logic                      pc_sel,
  input logic [CR_AW-1:0]          cr_addr,
  input logic [CR_DW-1:0]          cr_wdata,
  input logic [CR_DW-1:0]          cr_rdata,
  input logic                      sort_en,
  input logic [CR_DW-1:0]          det_threshold,
  input logic [CR_DW-1:0]          sep_a_slope,
  input logic [CR_DW-1:0]          sep_a_offset,
  input logic [CR_DW-1:0]          sep_b_slope,
  input logic [CR_DW-1:0]          sep_b_offset,
  input logic [SPK_LEN*COEF_W-1:0] pc1_coef,
  input logic [SPK_LEN*COEF_W-1:0] pc2_coef
);

  logic is_idle;
  assign is_idle = (op_mode == 3'd0) || (op_mode > 3'd4);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cr_rdata == '0) && !sort_en && (det_threshold == '0)
            && (pc1_coef == '0) && (pc2_coef == '0)); // R10

  AST_SORT_ON: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd4) |=> sort_en); // R8

  AST_SORT_OFF: assert property (@(posedge clk) disable iff (rst)
    (op_mode != 3'd4) |=> !sort_en); // R8

  AST_THRESH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd2) && in_valid && (cr_addr == '0)
    |=> det_threshold == $past(cr_wdata)); // R2

  AST_LINE_B_SLOPE_MAP: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd2) && in_valid && (cr_addr == 3)
    |=> sep_b_slope == $past(cr_wdata)); // R11

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd2) && !in_valid
    |=> $stable(det_threshold) && $stable(sep_a_slope) && $stable(sep_a_offset)
        && $stable(sep_b_slope) && $stable(sep_b_offset)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_mode != 3'd3) |=> $stable(cr_rdata)); // R4

  AST_PC1_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd1) && in_valid && !pc_sel
    |=> (pc1_coef[COEF_W-1:0] == $past(spk_sample))
        && (pc1_coef[2*COEF_W-1:COEF_W] == $past(pc1_coef[COEF_W-1:0]))
        && $stable(pc2_coef)); // R5

  AST_PC2_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd1) && in_valid && pc_sel
    |=> (pc2_coef[COEF_W-1:0] == $past(spk_sample)) && $stable(pc1_coef)); // R5

  AST_LOAD_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd1) && !in_valid
    |=> $stable(pc1_coef) && $stable(pc2_coef)); // R6

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    is_idle
    |=> $stable(pc1_coef) && $stable(pc2_coef) && $stable(cr_rdata)
        && $stable(det_threshold) && $stable(sep_a_slope) && $stable(sep_b_offset)
        && !sort_en); // R9 R1

endmodule

bind spk_cfg_ctrl spk_cfg_ctrl_chk #(
  .SPK_LEN (SPK_LEN),
  .COEF_W  (COEF_W),
  .CR_AW   (CR_AW),
  .CR_DW   (CR_DW)
) u_chk (.*);

// File: tb/spk_cfg_ctrl_tb.sv
module spk_cfg_ctrl_tb;

  localparam int unsigned SPK_LEN = 16;
  localparam int unsigned COEF_W  = 5;
  localparam int unsigned FLAT_W  = SPK_LEN * COEF_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        op_mode = 3'd0;
  logic              in_valid = 1'b0;
  logic [4:0]        spk_sample = '0;
  logic              pc_sel = 1'b0;
  logic [3:0]        cr_addr = '0;
  logic [7:0]        cr_wdata = '0;
  logic [7:0]        cr_rdata;
  logic              sort_en;
  logic [7:0]        det_threshold, sep_a_slope, sep_a_offset, sep_b_slope, sep_b_offset;
  logic [FLAT_W-1:0] pc1_coef, pc2_coef;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spk_cfg_ctrl u_dut (
    .clk (clk), .rst (rst), .op_mode (op_mode), .in_valid (in_valid),
    .spk_sample (spk_sample), .pc_sel (pc_sel), .cr_addr (cr_addr),
    .cr_wdata (cr_wdata), .cr_rdata (cr_rdata), .sort_en (sort_en),
    .det_threshold (det_threshold), .sep_a_slope (sep_a_slope),
    .sep_a_offset (sep_a_offset), .sep_b_slope (sep_b_slope),
    .sep_b_offset (sep_b_offset), .pc1_coef (pc1_coef), .pc2_coef (pc2_coef)
  );

  // Vector: {mode[3], valid, addr[4], wdata[8], exp_rdata[8], check_rdata}
  localparam int NVEC = 12;
  localparam logic [24:0] VEC [NVEC] = '{
    {3'd2, 1'b1, 4'd0,  8'h3C, 8'h00, 1'b0},  // R2 write threshold
    {3'd2, 1'b1, 4'd1,  8'hA5, 8'h00, 1'b0},  // R2 write slope A
    {3'd2, 1'b1, 4'd15, 8'h7E, 8'h00, 1'b0},  // R11 spare register
    {3'd2, 1'b0, 4'd1,  8'hFF, 8'h00, 1'b0},  // R3 write without valid
    {3'd3, 1'b0, 4'd0,  8'h00, 8'h3C, 1'b1},  // R4 read
    {3'd3, 1'b1, 4'd1,  8'h00, 8'hA5, 1'b1},  // R3 / R4
    {3'd3, 1'b0, 4'd15, 8'h00, 8'h7E, 1'b1},  // R11 spare readback
    {3'd4, 1'b1, 4'd0,  8'h55, 8'h7E, 1'b1},  // R8 sort, R4 hold
    {3'd5, 1'b1, 4'd0,  8'h11, 8'h7E, 1'b1},  // R1 idle alias
    {3'd3, 1'b0, 4'd0,  8'h00, 8'h3C, 1'b1},  // R1 threshold kept
    {3'd7, 1'b1, 4'd0,  8'h22, 8'h3C, 1'b1},  // R9 idle alias
    {3'd3, 1'b0, 4'd0,  8'h00, 8'h3C, 1'b1}   // R9 threshold kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic [2:0] m, input logic v, input logic sel,
                      input logic [3:0] a, input logic [7:0] wd, input logic [4:0] s);
    op_mode = m; in_valid = v; pc_sel = sel; cr_addr = a; cr_wdata = wd; spk_sample = s;
    @(negedge clk);
  endtask

  function automatic logic [4:0] samp(input int n);
    return 5'((n * 3 + 1) & 31);
  endfunction

  function automatic logic [4:0] ent(input logic [FLAT_W-1:0] f, input int k);
    return f[k*COEF_W +: COEF_W];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 rdata", cr_rdata, 0);
    chk("R10 sort_en", sort_en, 0);
    chk("R10 pc1", (pc1_coef == '0), 1);
    chk("R10 threshold", det_threshold, 0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      v = VEC[i];
      step(v[24:22], v[21], 1'b0, v[20:17], v[16:9], 5'd0);
      chk("R8 sort_en", sort_en, (v[24:22] == 3'd4));
      if (v[0]) chk("R4 rdata", cr_rdata, v[8:1]);
    end

    // R11 line taps
    step(3'd2, 1'b1, 1'b0, 4'd2, 8'h12, 5'd0);
    step(3'd2, 1'b1, 1'b0, 4'd3, 8'h34, 5'd0);
    step(3'd2, 1'b1, 1'b0, 4'd4, 8'h56, 5'd0);
    chk("R11 threshold", det_threshold, 8'h3C);
    chk("R11 slope A", sep_a_slope, 8'hA5);
    chk("R11 offset A", sep_a_offset, 8'h12);
    chk("R11 slope B", sep_b_slope, 8'h34);
    chk("R11 offset B", sep_b_offset, 8'h56);

    // R5 / R7 fill first memory
    for (int n = 0; n < SPK_LEN; n++) step(3'd1, 1'b1, 1'b0, 4'd0, 8'd0, samp(n));
    chk("R5 other memory untouched", (pc2_coef == '0), 1);
    for (int k = 0; k < SPK_LEN; k++) chk("R7 pc1 entry", ent(pc1_coef, k), samp(SPK_LEN-1-k));

    // R6 no shift without valid
    step(3'd1, 1'b0, 1'b0, 4'd0, 8'd0, 5'h1B);
    chk("R6 pc1 entry0", ent(pc1_coef, 0), samp(SPK_LEN-1));
    chk("R6 pc1 top", ent(pc1_coef, SPK_LEN-1), samp(0));

    // R5 second memory selected
    step(3'd1, 1'b1, 1'b1, 4'd0, 8'd0, 5'h1F);
    chk("R5 pc2 entry0", ent(pc2_coef, 0), 5'h1F);
    chk("R5 pc2 entry1", ent(pc2_coef, 1), 5'h00);
    chk("R5 pc1 kept", ent(pc1_coef, 0), samp(SPK_LEN-1));

    // R7 oldest sample discarded
    step(3'd1, 1'b1, 1'b0, 4'd0, 8'd0, 5'h0A);
    chk("R7 new entry0", ent(pc1_coef, 0), 5'h0A);
    chk("R7 top after drop", ent(pc1_coef, SPK_LEN-1), samp(1));

    // R9 idle codes with valid high keep coefficients
    step(3'd6, 1'b1, 1'b0, 4'd0, 8'h99, 5'h03);
    step(3'd0, 1'b1, 1'b1, 4'd0, 8'h99, 5'h03);
    chk("R9 pc1 kept", ent(pc1_coef, 0), 5'h0A);
    chk("R9 pc2 kept", ent(pc2_coef, 0), 5'h1F);
    chk("R9 threshold kept", det_threshold, 8'h3C);

    // R4 read latency: output changes only after the sampled read edge
    step(3'd3, 1'b0, 1'b0, 4'd2, 8'd0, 5'd0);
    chk("R4 read offset A", cr_rdata, 8'h12);

    // R10 mid-run reset
    rst = 1'b1;
    step(3'd4, 1'b0, 1'b0, 4'd0, 8'd0, 5'd0);
    rst = 1'b0;
    chk("R10 rdata cleared", cr_rdata, 0);
    chk("R10 sort_en cleared", sort_en, 0);
    chk("R10 pc1 cleared", (pc1_coef == '0), 1);
    chk("R10 pc2 cleared", (pc2_coef == '0), 1);
    chk("R10 slope A cleared", sep_a_slope, 0);
    step(3'd3, 1'b0, 1'b0, 4'd15, 8'd0, 5'd0);
    chk("R10 spare cleared", cr_rdata, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule